// File: doc/BRIEF.md
# Comparator Gain Trim Sequencer

This block trims the two input-stage gain codes of a three-input comparator so that the first and second integrator inputs end up weighted four and sixteen times the direct DAC input. Each gain is trimmed in its own pass, the first-integrator gain before the second. A pass begins by putting a fixed test code on the DAC, with its bitwise complement on the other half of the differential pair. It then pulses the residue-sampling phase and the charge-sharing phases that scale the residue down. For the first gain the residue goes through one sharing step, giving a quarter. For the second gain it goes through two steps, giving a sixteenth. Finally the DAC code is swapped, so the direct input carries a residue of the opposite sign.

With the residues in place, the block sweeps the gain code upward from zero. For each code it strobes the comparator several times and takes a majority vote. It locks the first code whose voted decision differs from the decision at code zero. The integrator input that is not being trimmed is held at common mode for the whole pass. If the decision never changes, the code stays at its top value and an error flag is set. Once both codes are settled, a done flag rises. The codes then stay fixed until the next start.

Top module: `cmp_gain_trim`

## Requirements
- R1: After reset, gain1 and gain2 are 0, and done and err are 0. No phase output and no comparator strobe is active.
- R2: A start accepted while idle or done clears both codes and err. It then runs this sequence:
  - the test code TC on dac_p and ~TC on dac_n, for one cycle on its own and then during the ph_sample cycle;
  - one ph_share1 cycle;
  - in the second pass only, one ph_share2 cycle right after ph_share1;
  - one more cycle, then the compare phase, with dac_p=~TC and dac_n=TC throughout.
- R3: During the first pass, hold_int2_cm is high and hold_int1_cm is low. During the second pass, while the DAC code is swapped, hold_int1_cm is high and hold_int2_cm is low. The two holds are never high together.
- R4: Each code is judged by VOTES (default 5) cmp_strobe cycles. Its decision is 1 when at least MAJ (default 3) of the sampled cmp_in values are 1.
- R5: Codes are tried in the order 0, 1, 2, and so on. The first code whose decision differs from the code-0 decision is locked.
- R6: If no code up to 7 changes the decision, the code locks at 7 and err goes high.
- R7: gain1 is trimmed first. gain2 stays 0 until the first pass is over.
- R8: done rises exactly 9+5*(n1+n2) cycles after the edge that accepts start, where n1 and n2 are the numbers of codes each pass tried. While done is high, both codes hold steady. A start pulse during a run is ignored.
- R9: At most one of ph_sample, ph_share1, ph_share2 and cmp_strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run |
| cmp_in | input | 1 | Comparator decision, sampled on strobe cycles |
| dac_p | output | DAC_W | Positive-side DAC code |
| dac_n | output | DAC_W | Negative-side DAC code |
| ph_sample | output | 1 | Residue sampling phase |
| ph_share1 | output | 1 | Charge share with first integration capacitor |
| ph_share2 | output | 1 | Charge share with second integration capacitor |
| hold_int1_cm | output | 1 | Tie first-integrator comparator input to common mode |
| hold_int2_cm | output | 1 | Tie second-integrator comparator input to common mode |
| cmp_strobe | output | 1 | Comparator decision request |
| gain1 | output | CODE_W | First-integrator gain code |
| gain2 | output | CODE_W | Second-integrator gain code |
| done | output | 1 | Both codes locked |
| err | output | 1 | A sweep saturated without a decision change |

## Verification
The analog model answers each strobe in the cycle it is issued, so a code's decision is registered on the edge that ends its fifth strobe, and the next code appears in the cycle after that. done is due 9+5*(n1+n2) cycles after the start edge. The driver pushes the expected codes, error flag and latency into a queue for each run, and the monitor pops the entry on the rising edge of done and compares the cycle count. Phase order, DAC polarity and the common-mode holds are checked in every cycle in which the corresponding strobe or phase is seen. All sampling happens on the falling clock edge.

// File: rtl/cmp_gain_trim.sv
module cmp_gain_trim #(
  parameter int CODE_W    = 3,
  parameter int DAC_W     = 10,
  parameter int TEST_CODE = 'h2A5,
  parameter int VOTES     = 5,
  parameter int MAJ       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmp_in,
  output logic [DAC_W-1:0]  dac_p,
  output logic [DAC_W-1:0]  dac_n,
  output logic              ph_sample,
  output logic              ph_share1,
  output logic              ph_share2,
  output logic              hold_int1_cm,
  output logic              hold_int2_cm,
  output logic              cmp_strobe,
  output logic [CODE_W-1:0] gain1,
  output logic [CODE_W-1:0] gain2,
  output logic              done,
  output logic              err
);
  localparam int VW = $clog2(VOTES + 1);
  localparam logic [DAC_W-1:0]  TC   = DAC_W'(TEST_CODE);
  localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

  typedef enum logic [2:0] {IDLE, LOAD, SAMP, SH1, SH2, FLIP, CMP, FIN} st_t;

  st_t         st;
  logic        stage, ref_pol;
  logic [VW-1:0] vcnt, ones;

  wire [VW-1:0]     ones_n    = ones + VW'(cmp_in);
  wire              last_vote = vcnt == VW'(VOTES - 1);
  wire              dec       = ones_n >= VW'(MAJ);
  wire [CODE_W-1:0] cur       = stage ? gain2 : gain1;
  wire              first     = cur == '0;
  wire              lock      = last_vote && !first && (dec != ref_pol);
  wire              sat       = last_vote && !lock && (cur == CMAX);
  wire              busy      = (st != IDLE) && (st != FIN);
  wire              rev       = (st == FLIP) || (st == CMP);

  assign dac_p        = busy ? (rev ? ~TC : TC) : '0;
  assign dac_n        = busy ? (rev ? TC : ~TC) : '0;
  assign ph_sample    = st == SAMP;
  assign ph_share1    = st == SH1;
  assign ph_share2    = st == SH2;
  assign cmp_strobe   = st == CMP;
  assign hold_int2_cm = busy && !stage;
  assign hold_int1_cm = stage && rev;
  assign done         = st == FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; stage <= 1'b0; ref_pol <= 1'b0;
      vcnt <= '0; ones <= '0;
      gain1 <= '0; gain2 <= '0; err <= 1'b0;
    end else begin
      case (st)
        IDLE, FIN: if (start) begin
          st <= LOAD; stage <= 1'b0;
          gain1 <= '0; gain2 <= '0; err <= 1'b0;
        end
        LOAD: st <= SAMP;
        SAMP: st <= SH1;
        SH1:  st <= stage ? SH2 : FLIP;
        SH2:  st <= FLIP;
        FLIP: begin st <= CMP; vcnt <= '0; ones <= '0; end
        CMP: begin
          if (!last_vote) begin
            vcnt <= vcnt + 1'b1;
            ones <= ones_n;
          end else begin
            vcnt <= '0;
            ones <= '0;
            if (first) ref_pol <= dec;
            if (lock || sat) begin
              if (sat) err <= 1'b1;
              if (stage) st <= FIN;
              else begin stage <= 1'b1; st <= LOAD; end
            end else if (stage) gain2 <= gain2 + 1'b1;
            else                gain1 <= gain1 + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_sample, ph_share1, ph_share2, cmp_strobe}));

  p_cm_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_int1_cm && hold_int2_cm));

  p_share_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_share1 |-> $past(ph_sample));

  p_gain2_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_int2_cm |-> gain2 == '0);

  p_codes_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(gain1) && $stable(gain2)));

  p_done_after_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmp_strobe));

  p_err_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (gain1 == CMAX || gain2 == CMAX));
endmodule

// File: tb/sim_cmp_gain_trim.sv
module sim_cmp_gain_trim;
  localparam int CLK_P = 10;
  localparam int DW = 10;
  localparam logic [DW-1:0] TC = 10'h2A5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_in = 1'b0;
  logic [DW-1:0] dac_p, dac_n;
  logic ph_sample, ph_share1, ph_share2, hold_int1_cm, hold_int2_cm, cmp_strobe;
  logic [2:0] gain1, gain2;
  logic done, err;

  cmp_gain_trim u0 (.clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .dac_p(dac_p), .dac_n(dac_n), .ph_sample(ph_sample), .ph_share1(ph_share1),
    .ph_share2(ph_share2), .hold_int1_cm(hold_int1_cm), .hold_int2_cm(hold_int2_cm),
    .cmp_strobe(cmp_strobe), .gain1(gain1), .gain2(gain2), .done(done), .err(err));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int g1; int g2; int e; int lat; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cyc = 0, t0 = 0;
  int th1 = 0, th2 = 0, vi = 0, seen2 = 0;
  bit pol = 1'b1, finished = 1'b0, prev_sh1 = 1'b0, prev_done = 1'b0;
  logic [4:0] noise = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit truth(input int g, input int th, input bit p);
    return p ? (g >= th) : (g < th);
  endfunction

  // analog model: answers each strobe within its cycle
  always @(negedge clk) begin
    if (cmp_strobe) begin
      int g, th;
      g  = seen2 != 0 ? int'(gain2) : int'(gain1);
      th = seen2 != 0 ? th2 : th1;
      cmp_in = truth(g, th, pol) ^ noise[vi];
      vi = (vi + 1) % 5;
    end
  end

  // monitor: phase, polarity and hold checks, and scoreboard pop
  always @(negedge clk) begin
    if (ph_sample)
      chk(dac_p == TC && dac_n == ~TC, "R2 test code at sample", int'(dac_p), int'(TC));
    if (ph_share2) begin
      chk(prev_sh1, "R2 share2 follows share1", int'(prev_sh1), 1);
      seen2 = 1;
    end
    if (cmp_strobe) begin
      chk(dac_p == ~TC && dac_n == TC, "R2 swapped code at compare", int'(dac_p), int'(~TC));
      if (seen2 == 0) begin
        chk(hold_int2_cm && !hold_int1_cm, "R3 int2 at cm in first pass",
            int'({hold_int1_cm, hold_int2_cm}), 1);
        chk(gain2 == 0, "R7 gain2 idle in first pass", int'(gain2), 0);
      end else
        chk(hold_int1_cm && !hold_int2_cm, "R3 int1 at cm in second pass",
            int'({hold_int1_cm, hold_int2_cm}), 2);
    end
    if (done && !prev_done) begin
      if (q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        exp_t x;
        x = q.pop_front();
        chk(int'(gain1) == x.g1, "R5 gain1 locked code", int'(gain1), x.g1);
        chk(int'(gain2) == x.g2, "R5 gain2 locked code", int'(gain2), x.g2);
        chk(int'(err) == x.e, "R6 error flag", int'(err), x.e);
        chk(cyc - t0 == x.lat, "R8 done latency", cyc - t0, x.lat);
      end
    end
    prev_sh1 = ph_share1;
    prev_done = done;
  end

  function automatic void expect_code(input int th, input bit p, output int code,
                                      output int n, output int e);
    code = 7; n = 8; e = 1;
    for (int c = 1; c < 8; c++)
      if (truth(c, th, p) != truth(0, th, p)) begin
        code = c; n = c + 1; e = 0;
        break;
      end
  endfunction

  task automatic run(input int a, input int b, input bit p, input logic [4:0] nz,
                     input bit restart_mid);
    exp_t x;
    int c1, n1, e1, c2, n2, e2;
    expect_code(a, p, c1, n1, e1);
    expect_code(b, p, c2, n2, e2);
    x.g1 = c1; x.g2 = c2; x.e = e1 | e2; x.lat = 9 + 5 * (n1 + n2);
    q.push_back(x);
    @(negedge clk);
    th1 = a; th2 = b; pol = p; noise = nz; vi = 0; seen2 = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    if (restart_mid) begin
      repeat (12) @(negedge clk);
      start = 1'b1;            // R8: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(int'(gain1) == c1 && int'(gain2) == c2 && done, "R8 codes steady while done",
        int'({gain1, gain2}), (c1 << 3) | c2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gain1 == 0 && gain2 == 0, "R1 codes at reset", int'({gain1, gain2}), 0);
    chk(!done && !err, "R1 flags at reset", int'({done, err}), 0);
    chk(!ph_sample && !ph_share1 && !ph_share2 && !cmp_strobe, "R1 phases idle",
        int'({ph_sample, ph_share1, ph_share2, cmp_strobe}), 0);
    rst_n = 1'b1;
    run(4, 5, 1'b1, 5'b00000, 1'b0);   // R5 rising crossing
    run(2, 6, 1'b0, 5'b00000, 1'b0);   // R5 falling crossing
    run(3, 3, 1'b1, 5'b10010, 1'b0);   // R4 two noisy votes of five
    run(1, 7, 1'b1, 5'b00101, 1'b0);   // R4 end codes
    run(0, 4, 1'b1, 5'b00000, 1'b0);   // R6 first sweep saturates
    run(5, 9, 1'b0, 5'b00000, 1'b0);   // R6 second sweep saturates
    run(6, 2, 1'b1, 5'b01000, 1'b1);   // R8 start during run ignored
    chk(q.size() == 0, "R8 every run finished", q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule